// File: doc/BRIEF.md
# Programmable Leaky Neuron Update Pipeline

This block updates the internal potentials of spiking neurons once per time slice, one potential per clock cycle. Each potential arrives as a stream beat with its stored value and the delta that was accumulated for it during the previous slice. The block decays the stored value by a per-filter leak factor and adds the delta. It then folds the result into a running membrane sum for the neuron, following a small per-filter operation code. On the neuron's last beat it compares the sum against a threshold, and it emits the neuron's address when the sum is above that threshold.

A neuron has up to eight filters, selected by a slot index carried with each beat. The operation codes are add, subtract, multiplicative linking, cascade and refractory. Cascade feeds the output of one filter into the next filter, which builds a higher-order kernel. The refractory filter raises the threshold; it is reloaded after a spike and leaks away over the following slices.

All neurons of a layer share one parameter set. That set is written through a simple load port between layers. Updated potentials leave on an output stream so they can be written back.

Top module: `neuron_update_pipe`

## Requirements
- R1: Every beat accepted with `in_valid` produces exactly one output beat three clock cycles later. That output beat carries the same slot index and neuron address. Beats accepted on consecutive cycles leave on consecutive cycles.
- R2: The updated value is `sat16(floor((p*r + 32768) / 65536) + d)`. Here `p` is the signed 16-bit stored value and `r` is the unsigned Q0.16 leak factor of the beat's slot. Saturation clamps to [-32768, 32767].
- R3: With `in_dtag` = 0 the delta input is ignored and the value is only decayed. With `in_tag` = 0 the stored value is taken as zero, so the result is the delta alone.
- R4: Operation code 0 adds the updated value to the neuron's membrane sum, and code 1 subtracts it. The sum is 24-bit signed and saturating, and it starts at zero for each neuron. Codes 5 to 7 leave the sum unchanged.
- R5: Code 2 (linking) modulates the sum multiplicatively: `sum <- sat24(sum + floor(sum*v / 256))`, which is `sum*(1 + v/256)`.
- R6: Code 3 (cascade) adds the updated value to the input of the next beat of the same neuron, on top of that beat's own delta. The cascaded value itself is not added to the sum. On a neuron's last beat, cascade has no effect.
- R7: Code 4 (refractory) keeps its value out of the sum and sets the threshold to `thr - v`. The neuron fires when the final sum is strictly greater than this dynamic threshold. With no refractory beat, `v` is 0.
- R8: When a neuron fires and its last beat has code 4, that beat's output value is replaced by `-eta0`.
- R9: `spk_valid` pulses with `spk_addr` equal to the neuron address, in the same cycle as the output of that neuron's last beat. It pulses at most once per neuron and never in any other cycle.
- R10: The parameter load port uses these addresses: 0 to 7 select a filter slot, with the leak factor in data[15:0] and the code in data[18:16]; 8 is the threshold, signed, in data[15:0]; 9 is eta0, unsigned, in data[14:0]. Writes to any other address have no effect. A written value applies to beats accepted after the write.
- R11: During and right after reset, `out_valid` and `spk_valid` are low. All parameters reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_pot | input | 16 | Stored potential, signed |
| in_tag | input | 1 | Stored potential is meaningful |
| in_delta | input | 16 | Accumulated delta, signed |
| in_dtag | input | 1 | Delta is valid |
| in_fidx | input | 3 | Filter slot of this beat |
| in_last | input | 1 | Last beat of the neuron |
| in_nrn | input | 10 | Neuron address |
| prm_we | input | 1 | Parameter write strobe |
| prm_addr | input | 4 | Parameter address |
| prm_data | input | 32 | Parameter data |
| out_valid | output | 1 | Output beat valid |
| out_pot | output | 16 | Updated potential, signed |
| out_fidx | output | 3 | Filter slot of output beat |
| out_nrn | output | 10 | Neuron address of output beat |
| spk_valid | output | 1 | Spike event valid |
| spk_addr | output | 10 | Address of the firing neuron |

## Verification
Directed patterns come first. Single-beat neurons isolate leak rounding, saturation and the two tag inputs. Pairs of beats separate add from subtract, show linking against a plain sum, and test cascade within a neuron against cascade across a neuron boundary. Two-slice sequences feed a reloaded refractory value back in and show that the same sum fires without it and stays silent with it; an exact-threshold case shows the comparison is strict. A long stretch of random neurons with random codes and random gaps then checks back-to-back timing against gapped timing, and a second layer's parameter set must take over cleanly.

// File: rtl/nup_pkg.sv
package nup_pkg;
  localparam int OPC_W = 3;
  localparam logic [OPC_W-1:0] OP_ADD  = 3'd0;
  localparam logic [OPC_W-1:0] OP_SUB  = 3'd1;
  localparam logic [OPC_W-1:0] OP_LINK = 3'd2;
  localparam logic [OPC_W-1:0] OP_CASC = 3'd3;
  localparam logic [OPC_W-1:0] OP_REFR = 3'd4;
endpackage

// File: rtl/nup_param_regs.sv
module nup_param_regs #(
  parameter int W      = 16,
  parameter int FILT   = 8,
  parameter int OPC_W  = 3,
  parameter int PRM_DW = 32,
  localparam int FIDX_W = $clog2(FILT),
  localparam int PRM_AW = $clog2(FILT + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [PRM_AW-1:0]   addr,
  input  logic [PRM_DW-1:0]   data,
  input  logic [FIDX_W-1:0]   rd_fidx,
  output logic [W-1:0]        rd_rate,
  output logic [OPC_W-1:0]    rd_op,
  output logic signed [W-1:0] thr,
  output logic [W-2:0]        eta0
);
  logic [W-1:0]     rate_arr [FILT];
  logic [OPC_W-1:0] op_arr   [FILT];

  // one register pair per filter slot
  for (genvar s = 0; s < FILT; s++) begin : g_slot
    logic [W-1:0]     rate_q;
    logic [OPC_W-1:0] op_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        rate_q <= '0;
        op_q   <= '0;
      end else if (we && addr == PRM_AW'(s)) begin
        rate_q <= data[W-1:0];
        op_q   <= data[W+OPC_W-1:W];
      end
    end
    assign rate_arr[s] = rate_q;
    assign op_arr[s]   = op_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr  <= '0;
      eta0 <= '0;
    end else if (we) begin
      if (addr == PRM_AW'(FILT))     thr  <= data[W-1:0];
      if (addr == PRM_AW'(FILT + 1)) eta0 <= data[W-2:0];
    end
  end

  assign rd_rate = rate_arr[rd_fidx];
  assign rd_op   = op_arr[rd_fidx];
endmodule

// File: rtl/nup_filter_stage.sv
module nup_filter_stage
  import nup_pkg::*;
#(
  parameter int W      = 16,
  parameter int FIDX_W = 3,
  parameter int NRN_W  = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_pot,
  input  logic                in_tag,
  input  logic signed [W-1:0] in_delta,
  input  logic                in_dtag,
  input  logic [FIDX_W-1:0]   in_fidx,
  input  logic                in_last,
  input  logic [NRN_W-1:0]    in_nrn,
  input  logic [W-1:0]        rate,
  input  logic [OPC_W-1:0]    op,
  output logic                b_valid,
  output logic signed [W-1:0] b_val,
  output logic [OPC_W-1:0]    b_op,
  output logic                b_last,
  output logic [FIDX_W-1:0]   b_fidx,
  output logic [NRN_W-1:0]    b_nrn
);
  localparam int PW = 2 * W + 1;
  localparam int SW = W + 2;
  localparam logic signed [PW-1:0] HALF  = {{(W+1){1'b0}}, 1'b1, {(W-1){1'b0}}};
  localparam logic signed [PW-1:0] PMAX  = {{(W+2){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PW-1:0] PMIN  = {{(W+2){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [SW-1:0] SMAX  = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [SW-1:0] SMIN  = {3'b111, {(W-1){1'b0}}};

  // stage A: leak multiply with round-half-up
  logic signed [W-1:0]  pot_sel;
  logic signed [PW-1:0] prod, prod_sh;
  logic signed [W-1:0]  dec;
  assign pot_sel = in_tag ? in_pot : '0;
  assign prod    = $signed({{(W+1){pot_sel[W-1]}}, pot_sel}) * $signed({{(W+1){1'b0}}, rate});
  assign prod_sh = (prod + HALF) >>> W;
  always_comb begin
    if (prod_sh > PMAX)      dec = PMAX[W-1:0];
    else if (prod_sh < PMIN) dec = PMIN[W-1:0];
    else                     dec = prod_sh[W-1:0];
  end

  logic                a_valid, a_last;
  logic signed [W-1:0] a_dec, a_delta;
  logic [OPC_W-1:0]    a_op;
  logic [FIDX_W-1:0]   a_fidx;
  logic [NRN_W-1:0]    a_nrn;

  always_ff @(posedge clk) begin
    if (rst) a_valid <= 1'b0;
    else     a_valid <= in_valid;
    if (in_valid) begin
      a_dec   <= dec;
      a_delta <= in_dtag ? in_delta : '0;
      a_op    <= op;
      a_last  <= in_last;
      a_fidx  <= in_fidx;
      a_nrn   <= in_nrn;
    end
  end

  // stage B: add delta plus cascaded value of the previous beat
  logic                b_casc;
  logic signed [W-1:0] carry;
  logic signed [SW-1:0] sum;
  logic signed [W-1:0] nv;
  assign carry = b_casc ? b_val : '0;
  assign sum = $signed({{2{a_dec[W-1]}}, a_dec}) + $signed({{2{a_delta[W-1]}}, a_delta})
             + $signed({{2{carry[W-1]}}, carry});
  always_comb begin
    if (sum > SMAX)      nv = SMAX[W-1:0];
    else if (sum < SMIN) nv = SMIN[W-1:0];
    else                 nv = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_valid <= 1'b0;
      b_casc  <= 1'b0;
      b_val   <= '0;
    end else begin
      b_valid <= a_valid;
      if (a_valid) begin
        b_val  <= nv;
        b_casc <= (a_op == OP_CASC) && !a_last;
      end
    end
    if (a_valid) begin
      b_op   <= a_op;
      b_last <= a_last;
      b_fidx <= a_fidx;
      b_nrn  <= a_nrn;
    end
  end
endmodule

// File: rtl/nup_soma_stage.sv
module nup_soma_stage
  import nup_pkg::*;
#(
  parameter int W       = 16,
  parameter int ACC_W   = 24,
  parameter int FIDX_W  = 3,
  parameter int NRN_W   = 10,
  parameter int LINK_SH = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                b_valid,
  input  logic signed [W-1:0] b_val,
  input  logic [OPC_W-1:0]    b_op,
  input  logic                b_last,
  input  logic [FIDX_W-1:0]   b_fidx,
  input  logic [NRN_W-1:0]    b_nrn,
  input  logic signed [W-1:0] thr,
  input  logic [W-2:0]        eta0,
  output logic                out_valid,
  output logic signed [W-1:0] out_pot,
  output logic [FIDX_W-1:0]   out_fidx,
  output logic [NRN_W-1:0]    out_nrn,
  output logic                spk_valid,
  output logic [NRN_W-1:0]    spk_addr
);
  localparam int LW = ACC_W + W;
  localparam int XW = LW + 1;
  localparam logic signed [XW-1:0] AMAX = {{(W+2){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [XW-1:0] AMIN = {{(W+2){1'b1}}, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc, acc_next, thr_eff;
  logic signed [W-1:0]     refr, refr_cur, neg_eta;
  logic signed [LW-1:0]    lprod;
  logic signed [XW-1:0]    ext_acc, ext_v, wide;
  logic                    fire;

  assign ext_acc = $signed({{(W+1){acc[ACC_W-1]}}, acc});
  assign ext_v   = $signed({{(ACC_W+1){b_val[W-1]}}, b_val});
  assign lprod   = $signed({{W{acc[ACC_W-1]}}, acc}) * $signed({{ACC_W{b_val[W-1]}}, b_val});

  always_comb begin
    case (b_op)
      OP_ADD:  wide = ext_acc + ext_v;
      OP_SUB:  wide = ext_acc - ext_v;
      OP_LINK: wide = ext_acc + ($signed({lprod[LW-1], lprod}) >>> LINK_SH);
      default: wide = ext_acc;
    endcase
    if (wide > AMAX)      acc_next = AMAX[ACC_W-1:0];
    else if (wide < AMIN) acc_next = AMIN[ACC_W-1:0];
    else                  acc_next = wide[ACC_W-1:0];
  end

  // dynamic threshold: static level raised by the refractory potential
  assign refr_cur = (b_op == OP_REFR) ? b_val : refr;
  assign thr_eff  = $signed({{(ACC_W-W){thr[W-1]}}, thr})
                  - $signed({{(ACC_W-W){refr_cur[W-1]}}, refr_cur});
  assign fire     = b_valid && b_last && (acc_next > thr_eff);
  assign neg_eta  = '0 - $signed({1'b0, eta0});

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      spk_valid <= 1'b0;
      acc       <= '0;
      refr      <= '0;
    end else begin
      out_valid <= b_valid;
      spk_valid <= fire;
      if (b_valid) begin
        acc  <= b_last ? '0 : acc_next;
        refr <= b_last ? '0 : refr_cur;
      end
    end
    if (b_valid) begin
      out_pot  <= (fire && b_op == OP_REFR) ? neg_eta : b_val;
      out_fidx <= b_fidx;
      out_nrn  <= b_nrn;
      spk_addr <= b_nrn;
    end
  end
endmodule

// File: rtl/neuron_update_pipe.sv
module neuron_update_pipe
  import nup_pkg::*;
#(
  parameter int W       = 16,
  parameter int FILT    = 8,
  parameter int NRN_W   = 10,
  parameter int ACC_W   = 24,
  parameter int LINK_SH = 8,
  parameter int PRM_DW  = 32,
  localparam int FIDX_W = $clog2(FILT),
  localparam int PRM_AW = $clog2(FILT + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_pot,
  input  logic                in_tag,
  input  logic signed [W-1:0] in_delta,
  input  logic                in_dtag,
  input  logic [FIDX_W-1:0]   in_fidx,
  input  logic                in_last,
  input  logic [NRN_W-1:0]    in_nrn,
  input  logic                prm_we,
  input  logic [PRM_AW-1:0]   prm_addr,
  input  logic [PRM_DW-1:0]   prm_data,
  output logic                out_valid,
  output logic signed [W-1:0] out_pot,
  output logic [FIDX_W-1:0]   out_fidx,
  output logic [NRN_W-1:0]    out_nrn,
  output logic                spk_valid,
  output logic [NRN_W-1:0]    spk_addr
);
  logic [W-1:0]        rate;
  logic [OPC_W-1:0]    op;
  logic signed [W-1:0] thr;
  logic [W-2:0]        eta0;

  logic                b_valid, b_last;
  logic signed [W-1:0] b_val;
  logic [OPC_W-1:0]    b_op;
  logic [FIDX_W-1:0]   b_fidx;
  logic [NRN_W-1:0]    b_nrn;

  nup_param_regs #(.W(W), .FILT(FILT), .OPC_W(OPC_W), .PRM_DW(PRM_DW)) u_prm (
    .clk(clk), .rst(rst), .we(prm_we), .addr(prm_addr), .data(prm_data),
    .rd_fidx(in_fidx), .rd_rate(rate), .rd_op(op), .thr(thr), .eta0(eta0)
  );

  nup_filter_stage #(.W(W), .FIDX_W(FIDX_W), .NRN_W(NRN_W)) u_flt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pot(in_pot), .in_tag(in_tag),
    .in_delta(in_delta), .in_dtag(in_dtag), .in_fidx(in_fidx), .in_last(in_last),
    .in_nrn(in_nrn), .rate(rate), .op(op), .b_valid(b_valid), .b_val(b_val),
    .b_op(b_op), .b_last(b_last), .b_fidx(b_fidx), .b_nrn(b_nrn)
  );

  nup_soma_stage #(.W(W), .ACC_W(ACC_W), .FIDX_W(FIDX_W), .NRN_W(NRN_W),
                   .LINK_SH(LINK_SH)) u_soma (
    .clk(clk), .rst(rst), .b_valid(b_valid), .b_val(b_val), .b_op(b_op),
    .b_last(b_last), .b_fidx(b_fidx), .b_nrn(b_nrn), .thr(thr), .eta0(eta0),
    .out_valid(out_valid), .out_pot(out_pot), .out_fidx(out_fidx),
    .out_nrn(out_nrn), .spk_valid(spk_valid), .spk_addr(spk_addr)
  );
endmodule

// File: rtl/nup_checker.sv
module nup_checker #(
  parameter int FIDX_W = 3,
  parameter int NRN_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [FIDX_W-1:0] in_fidx,
  input logic [NRN_W-1:0]  in_nrn,
  input logic              out_valid,
  input logic [FIDX_W-1:0] out_fidx,
  input logic [NRN_W-1:0]  out_nrn,
  input logic              spk_valid,
  input logic [NRN_W-1:0]  spk_addr
);
  // R1: every accepted beat leaves three cycles later
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##2 out_valid);
  // R1: no output beat without an input beat
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##2 !out_valid);
  // R1: slot and neuron address travel with the beat
  p_tags_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##2 (out_fidx == $past(in_fidx, 3) && out_nrn == $past(in_nrn, 3)));
  // R9: a spike coincides with an output beat of the same neuron
  p_spk_beat_r9: assert property (@(posedge clk) disable iff (rst)
    spk_valid |-> (out_valid && spk_addr == out_nrn));
  // R11: reset clears both valid outputs
  p_reset_r11: assert property (@(posedge clk)
    rst |=> (!out_valid && !spk_valid));
endmodule

bind neuron_update_pipe nup_checker #(.FIDX_W(FIDX_W), .NRN_W(NRN_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_fidx(in_fidx), .in_nrn(in_nrn),
  .out_valid(out_valid), .out_fidx(out_fidx), .out_nrn(out_nrn),
  .spk_valid(spk_valid), .spk_addr(spk_addr)
);

// File: tb/tb_neuron_update_pipe.sv
`timescale 1ns/1ps
module tb_neuron_update_pipe;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst;
  logic               in_valid, in_tag, in_dtag, in_last;
  logic signed [15:0] in_pot, in_delta;
  logic [2:0]         in_fidx;
  logic [9:0]         in_nrn;
  logic               prm_we;
  logic [3:0]         prm_addr;
  logic [31:0]        prm_data;
  logic               out_valid, spk_valid;
  logic signed [15:0] out_pot;
  logic [2:0]         out_fidx;
  logic [9:0]         out_nrn, spk_addr;

  neuron_update_pipe dut (.*);

  typedef struct {int due; int pot; int fidx; int nrn; bit spk; string req;} exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit running = 0;
  string cur_req = "R11";

  // behavioural reference state
  int m_rate[8], m_op[8], m_thr = 0, m_eta = 0, m_refr = 0, m_prev = 0, m_lastout = 0;
  longint m_acc = 0;
  bit m_casc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint sat(longint x, int bits);
    longint hi = (64'sd1 <<< (bits - 1)) - 1;
    longint lo = -(64'sd1 <<< (bits - 1));
    return (x > hi) ? hi : (x < lo) ? lo : x;
  endfunction

  task automatic beat(int pot, bit tag, int d, bit dt, int f, bit last, int nrn);
    longint dec, nv, thr_eff;
    int outv;
    bit fire;
    exp_t e;
    @(negedge clk);
    in_valid = 1; in_pot = 16'(pot); in_tag = tag; in_delta = 16'(d);
    in_dtag = dt; in_fidx = 3'(f); in_last = last; in_nrn = 10'(nrn);
    dec = tag ? sat((longint'(pot) * m_rate[f] + 32768) >>> 16, 16) : 0;
    nv  = sat(dec + (dt ? d : 0) + (m_casc ? m_prev : 0), 16);
    m_prev = int'(nv);
    m_casc = (m_op[f] == 3) && !last;
    case (m_op[f])
      0: m_acc = sat(m_acc + nv, 24);
      1: m_acc = sat(m_acc - nv, 24);
      2: m_acc = sat(m_acc + ((m_acc * nv) >>> 8), 24);
      4: m_refr = int'(nv);
      default: ;
    endcase
    thr_eff = longint'(m_thr) - m_refr;
    fire = last && (m_acc > thr_eff);
    outv = (fire && m_op[f] == 4) ? -m_eta : int'(nv);
    m_lastout = outv;
    e.due = cyc + 3; e.pot = outv; e.fidx = f; e.nrn = nrn; e.spk = fire; e.req = cur_req;
    q.push_back(e);
    if (last) begin m_acc = 0; m_refr = 0; end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  task automatic ld(int a, int data);
    idle(4);
    @(negedge clk);
    prm_we = 1; prm_addr = 4'(a); prm_data = data;
    if (a < 8) begin m_rate[a] = data & 32'hFFFF; m_op[a] = (data >> 16) & 7; end
    else if (a == 8) m_thr = int'($signed(16'(data)));
    else if (a == 9) m_eta = data & 32'h7FFF;
    @(negedge clk);
    prm_we = 0;
  endtask

  // compare against the reference on every cycle
  always @(negedge clk) begin
    if (running) begin
      bit ev;
      exp_t e;
      ev = 0;
      while (q.size() > 0 && q[0].due < cyc) begin
        e = q.pop_front();
        checks++; errors++;
        $display("FAIL %s: output beat missing, got none exp pot %0d", e.req, e.pot);
      end
      if (q.size() > 0 && q[0].due == cyc) begin ev = 1; e = q.pop_front(); end
      if (ev || out_valid || spk_valid) begin
        checks++;
        if (out_valid !== ev) begin
          errors++;
          $display("FAIL %s: out_valid got %0b exp %0b", ev ? e.req : "R1", out_valid, ev);
        end else if (int'(out_pot) != e.pot || int'(out_fidx) != e.fidx || int'(out_nrn) != e.nrn) begin
          errors++;
          $display("FAIL %s: beat got pot %0d slot %0d nrn %0d exp pot %0d slot %0d nrn %0d",
                   e.req, out_pot, out_fidx, out_nrn, e.pot, e.fidx, e.nrn);
        end
        checks++;
        if (spk_valid !== (ev && e.spk) || (spk_valid && int'(spk_addr) != e.nrn)) begin
          errors++;
          $display("FAIL R9 (%s): spike got %0b addr %0d exp %0b addr %0d",
                   ev ? e.req : "R9", spk_valid, spk_addr, ev && e.spk, ev ? e.nrn : 0);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run not finished, got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_rate[i] = 0; m_op[i] = 0; end
    rst = 1; in_valid = 0; in_pot = 0; in_tag = 0; in_delta = 0; in_dtag = 0;
    in_fidx = 0; in_last = 0; in_nrn = 0; prm_we = 0; prm_addr = 0; prm_data = 0;
    repeat (5) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || spk_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11: valids got %0b/%0b exp 0/0", out_valid, spk_valid);
    end
    rst = 0;
    running = 1;
    idle(2);

    // layer 1 parameters (R10: slot code in [18:16], leak in [15:0])
    cur_req = "R10";
    ld(0, (0 << 16) | 32'h8000);
    ld(1, (1 << 16) | 32'hC000);
    ld(2, (2 << 16) | 32'h4000);
    ld(3, (3 << 16) | 32'hE000);
    ld(4, (0 << 16) | 32'hF000);
    ld(5, (5 << 16) | 32'hFFFF);
    ld(7, (4 << 16) | 32'h8000);
    ld(8, 100);
    ld(9, 200);
    ld(12, 32'h0007FFFF);   // unmapped address, must change nothing
    idle(2);

    cur_req = "R2";  // leak, rounding, saturation
    beat(1000, 1, 7, 1, 0, 1, 1);
    beat(-3, 1, 0, 1, 0, 1, 2);
    beat(3, 1, 0, 1, 0, 1, 3);
    beat(-32768, 1, -30000, 1, 0, 1, 4);
    beat(32767, 1, 32767, 1, 5, 1, 5);
    idle(2);
    cur_req = "R3";  // delta ignored without its tag, value zero without its tag
    beat(1000, 1, 999, 0, 0, 1, 6);
    beat(12345, 0, 20, 1, 0, 1, 7);
    beat(12345, 0, 20, 0, 1, 1, 8);
    idle(2);
    cur_req = "R4";  // add, subtract, ignored code
    beat(600, 1, 0, 1, 0, 0, 9);
    beat(800, 1, 0, 1, 1, 1, 9);
    beat(600, 1, 0, 1, 0, 0, 10);
    beat(100, 1, 0, 1, 1, 1, 10);
    beat(600, 1, 0, 1, 0, 0, 11);
    beat(20000, 1, 0, 1, 5, 1, 11);
    idle(2);
    cur_req = "R5";  // linking modulation, positive and negative
    beat(180, 1, 0, 1, 0, 0, 12);
    beat(400, 1, 0, 1, 2, 1, 12);
    beat(180, 1, 0, 1, 0, 0, 13);
    beat(-600, 1, 0, 1, 2, 1, 13);
    idle(3);
    cur_req = "R6";  // cascade within a neuron and across a boundary
    beat(1000, 1, 0, 1, 3, 0, 14);
    beat(0, 0, 0, 0, 4, 1, 14);
    beat(1000, 1, 0, 1, 3, 1, 15);
    beat(0, 0, 0, 0, 4, 1, 16);
    idle(2);
    cur_req = "R7";  // strict compare at the threshold
    beat(200, 1, 0, 1, 0, 1, 17);   // 100 == thr, no spike
    beat(202, 1, 0, 1, 0, 1, 18);   // 101 > thr, spike
    idle(2);
    cur_req = "R8";  // fire reloads refractory, next slice is held back
    beat(400, 1, 0, 1, 0, 0, 19);
    beat(0, 0, 0, 0, 7, 1, 19);
    idle(4);
    beat(300, 1, 0, 1, 0, 0, 19);
    beat(m_lastout, 1, 0, 1, 7, 1, 19);
    cur_req = "R7";
    beat(300, 1, 0, 1, 0, 0, 20);
    beat(0, 0, 0, 0, 7, 1, 20);
    idle(4);

    cur_req = "R1";  // random neurons, random gaps
    for (int n = 0; n < 300; n++) begin
      int nb;
      nb = 1 + ($urandom % 4);
      for (int b = 0; b < nb; b++) begin
        beat(int'($urandom_range(0, 65535)) - 32768, 1'($urandom), int'($urandom_range(0, 4095)) - 2048,
             1'($urandom), int'($urandom % 8), b == nb - 1, n);
        if ($urandom % 4 == 0) idle(1);
      end
    end
    idle(2);

    cur_req = "R10";  // second layer parameters take over
    ld(0, (1 << 16) | 32'hA000);
    ld(8, -50);
    ld(9, 32767);
    ld(7, (4 << 16) | 32'h2000);
    cur_req = "R10";
    beat(-400, 1, 0, 1, 0, 0, 21);
    beat(0, 0, 0, 0, 7, 1, 21);
    beat(-400, 1, 5, 1, 0, 1, 22);
    idle(2);
    cur_req = "R9";  // back-to-back single-beat neurons, one spike each
    for (int n = 0; n < 20; n++) beat(-2000 + 100 * n, 1, 0, 1, 0, 1, 100 + n);
    idle(6);

    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1: pending beats got %0d exp 0", q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule